// File: doc/BRIEF.md
# Double-Buffered Waveguide Delay-Line Resampler

This block holds one circular delay line for a digital waveguide and keeps it in two equal RAM banks. One bank is live. On every sample strobe it returns the sample written one line-length earlier and stores the new input in its place. The other bank sits idle as a shadow.

When the pitch changes, the host asks for a new line length. With the length it supplies a precomputed reciprocal, `floor(65536 / N)`, so no divider is needed. The block then rebuilds the line in the shadow bank as a linearly interpolated, time-scaled copy of the live contents:

- A shorter length compresses the waveform.
- A longer length stretches it.

The copy starts from the live read pointer, so the waveform keeps its phase. Once the copy is done, the two banks trade roles and playback continues from the rescaled data.

The copy runs on the fast system clock and fills two destination samples per cycle, one on each write port of the shadow bank. Sample traffic on the live bank carries on while the copy runs.

The controller is a four-state machine:

- **IDLE**: waits for work. It leaves to PREP when a legal request arrives or one is pending (transition *accept*).
- **PREP**: snapshots the read pointer and forms the position step `old_len * recip`. It always moves on to COPY (transition *start*).
- **COPY**: writes two destinations per cycle. It moves to SWAP once the last destination has been written (transition *done*).
- **SWAP**: exchanges the banks and returns to IDLE (transition *commit*). If a sample strobe lands in that cycle, SWAP stays put for one cycle (transition *defer*).

Top module: `wg_resampler`

## Requirements
- R1: After reset, `smp_out` is 0, `busy` is 0, `len_err` is 0, and the line length is `INIT_LEN`.
- R2: For line length L, each `smp_tick` latches into `smp_out`, by the next clock edge, the sample written L strobes earlier. The same strobe stores `smp_in`.
- R3: A request with `chg_len` in 2..MAXLEN makes `busy` high from the next cycle. If no strobe or second request intervenes, `busy` stays high for exactly `ceil(N/2) + 2` cycles. This reflects two destination samples per copy cycle.
- R4: Let `p` be the live read pointer when the copy starts. Destination j gets position `pos = j * L * chg_recip`, a value with 16 fractional bits. Its index `i = pos >> 16` is clamped to L-1, and its fraction is `f = pos & 0xFFFF`. Let `a` be the sample at `(p+i) mod L` and `b` the sample at `(p+i+1) mod L`, both read as two's-complement. The destination value is `a + floor((b-a)*f / 65536)`, truncated to DW bits. The value for j = 0..N-1 appears on `smp_out` at the (j+1)-th strobe after the swap. This covers both compression (N < L) and stretching (N > L).
- R5: After the swap, the line length is N, and each strobe returns the sample written N strobes earlier.
- R6: A legal request that arrives while a copy is under way is latched and started right after the current swap, with `busy` held high throughout. A later such request replaces an earlier pending one.
- R7: A request with `chg_len` below 2 or above MAXLEN is ignored. `len_err` is high for exactly the one cycle after it. `busy`, the length and the line contents are unchanged.
- R8: Strobes during a copy are served from the live bank with the old length, with no missed or repeated samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample-rate strobe |
| smp_in | input | DW | Sample entering the delay line |
| smp_out | output | DW | Sample leaving the delay line, updated on each strobe |
| chg_req | input | 1 | One-cycle length-change request |
| chg_len | input | LW | Requested new length |
| chg_recip | input | RW | `floor(65536 / chg_len)` for the requested length |
| busy | output | 1 | A resample is in progress or pending |
| len_err | output | 1 | One-cycle pulse: the request was out of range |

## Verification
The checker watches several rules on every cycle:

- The read pointer advances and wraps by one on each strobe.
- The length stays legal.
- A swap flips the bank, zeroes the pointer and lands in IDLE.
- COPY never lasts more than MAXLEN/2 cycles.
- Every error pulse comes from an out-of-range request, and such a request leaves `busy` and the length alone.
- A legal request raises `busy`.

Only the bench scenarios can show that the interpolated data are numerically right. The same goes for the exact copy duration, queued requests being served in order, and delay behaviour before and after a swap.

// File: rtl/wgr_pkg.sv
package wgr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_COPY,
        ST_SWAP
    } wgr_state_e;

    localparam int FRAC_W = 16;
endpackage

// File: rtl/wgr_bank.sv
// One delay-line bank: two write ports, NRD combinational read ports.
module wgr_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 1024,
    parameter int NRD   = 5,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we_a,
    input  logic [AW-1:0]            wa_a,
    input  logic [DW-1:0]            wd_a,
    input  logic                     we_b,
    input  logic [AW-1:0]            wa_b,
    input  logic [DW-1:0]            wd_b,
    input  logic [NRD-1:0][AW-1:0]   ra,
    output logic [NRD-1:0][DW-1:0]   rd
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) mem[wa_a] <= wd_a;
        if (we_b) mem[wb_sel(wa_b)] <= wd_b;
    end

    function automatic logic [AW-1:0] wb_sel(input logic [AW-1:0] x);
        return x;
    endfunction

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd[g] = mem[ra[g]];
    end
endmodule

// File: rtl/wgr_lerp.sv
// Linear interpolation a + floor((b-a)*frac / 2^FW), truncated to DW bits.
module wgr_lerp #(
    parameter int DW = 16,
    parameter int FW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [FW-1:0] frac,
    output logic [DW-1:0] y
);
    logic signed [DW:0]       diff;
    logic signed [DW+FW+1:0]  prod;
    logic signed [DW+FW+1:0]  shf;

    assign diff = $signed({b[DW-1], b}) - $signed({a[DW-1], a});
    assign prod = diff * $signed({1'b0, frac});
    assign shf  = prod >>> FW;
    assign y    = a + shf[DW-1:0];
endmodule

// File: rtl/wg_resampler.sv
module wg_resampler #(
    parameter int DW        = 16,
    parameter int MAXLEN    = 1024,
    parameter int INIT_LEN  = 16,
    localparam int LW       = $clog2(MAXLEN + 1),
    localparam int RW       = wgr_pkg::FRAC_W + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_tick,
    input  logic [DW-1:0] smp_in,
    output logic [DW-1:0] smp_out,
    input  logic          chg_req,
    input  logic [LW-1:0] chg_len,
    input  logic [RW-1:0] chg_recip,
    output logic          busy,
    output logic          len_err
);
    import wgr_pkg::*;

    localparam int AW  = $clog2(MAXLEN);
    localparam int FW  = FRAC_W;
    localparam int PW  = LW + RW + 1;
    localparam int NRD = 5;

    wgr_state_e st, st_nx;

    logic          act;
    logic [AW-1:0] ptr;
    logic [LW-1:0] cur_len;
    logic [LW-1:0] tgt_len;
    logic [RW-1:0] tgt_rcp;
    logic          pend_v;
    logic [LW-1:0] pend_len;
    logic [RW-1:0] pend_rcp;
    logic [AW-1:0] base;
    logic [PW-1:0] step;
    logic [PW-1:0] acc;
    logic [LW-1:0] dst_j;
    logic          req_ok;
    logic          copy_last;

    logic [NRD-1:0][AW-1:0] src_ra;
    logic [NRD-1:0][DW-1:0] bank_rd [2];
    logic [NRD-1:0][DW-1:0] rd_act;
    logic [1:0]             lane_we;
    logic [1:0][AW-1:0]     lane_wa;
    logic [1:0][DW-1:0]     lane_wd;
    logic [1:0][FW-1:0]     lane_fr;

    // Circular source address: base + idx (+1), wrapped at len, idx clamped.
    function automatic logic [AW-1:0] src_addr(
        input logic [PW-1:0] pos,
        input logic [LW-1:0] len,
        input logic [AW-1:0] b0,
        input logic          nxt
    );
        logic [LW:0] idx;
        logic [LW:0] s;
        idx = {1'b0, pos[FW +: LW]};
        if (idx >= {1'b0, len}) idx = {1'b0, len} - 1'b1;
        s = (LW+1)'(b0) + idx + (LW+1)'(nxt);
        if (s >= {1'b0, len}) s = s - {1'b0, len};
        return s[AW-1:0];
    endfunction

    assign req_ok    = chg_req && (chg_len >= LW'(2)) && (chg_len <= LW'(MAXLEN));
    assign copy_last = ({1'b0, dst_j} + (LW+1)'(2)) >= {1'b0, tgt_len};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (pend_v || req_ok) st_nx = ST_PREP;   // accept
            ST_PREP: st_nx = ST_COPY;                        // start
            ST_COPY: if (copy_last) st_nx = ST_SWAP;         // done
            ST_SWAP: if (!smp_tick) st_nx = ST_IDLE;         // commit / defer
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    always_comb begin
        busy    = (st != ST_IDLE) || pend_v;
        rd_act  = act ? bank_rd[1] : bank_rd[0];
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act      <= 1'b0;
            ptr      <= '0;
            cur_len  <= LW'(INIT_LEN);
            tgt_len  <= LW'(INIT_LEN);
            tgt_rcp  <= '0;
            pend_v   <= 1'b0;
            pend_len <= '0;
            pend_rcp <= '0;
            base     <= '0;
            step     <= '0;
            acc      <= '0;
            dst_j    <= '0;
            smp_out  <= '0;
            len_err  <= 1'b0;
        end else begin
            len_err <= chg_req && !req_ok;

            // request intake and queueing
            if (st == ST_IDLE) begin
                if (pend_v) begin
                    tgt_len <= pend_len;
                    tgt_rcp <= pend_rcp;
                    pend_v  <= req_ok;
                    if (req_ok) begin
                        pend_len <= chg_len;
                        pend_rcp <= chg_recip;
                    end
                end else if (req_ok) begin
                    tgt_len <= chg_len;
                    tgt_rcp <= chg_recip;
                end
            end else if (req_ok) begin
                pend_v   <= 1'b1;
                pend_len <= chg_len;
                pend_rcp <= chg_recip;
            end

            // copy sequencing
            unique case (st)
                ST_PREP: begin
                    base  <= ptr;
                    step  <= PW'(cur_len) * PW'(tgt_rcp);
                    acc   <= '0;
                    dst_j <= '0;
                end
                ST_COPY: begin
                    acc   <= acc + (step << 1);
                    dst_j <= dst_j + LW'(2);
                end
                default: ;
            endcase

            // playback and bank exchange (exchange waits for a strobe-free cycle)
            if (st == ST_SWAP && !smp_tick) begin
                act     <= ~act;
                ptr     <= '0;
                cur_len <= tgt_len;
            end else if (smp_tick) begin
                smp_out <= rd_act[0];
                if (({1'b0, ptr} + (LW+1)'(1)) == {1'b0, cur_len}) ptr <= '0;
                else                                             ptr <= ptr + 1'b1;
            end
        end
    end

    // ---------------- copy lanes ----------------
    assign src_ra[0] = ptr;

    for (genvar k = 0; k < 2; k++) begin : g_lane
        logic [PW-1:0] pos;
        logic [LW-1:0] dst_n;
        assign pos          = (k == 0) ? acc : acc + step;
        assign dst_n        = dst_j + LW'(k);
        assign src_ra[1+2*k] = src_addr(pos, cur_len, base, 1'b0);
        assign src_ra[2+2*k] = src_addr(pos, cur_len, base, 1'b1);
        assign lane_fr[k]   = pos[FW-1:0];
        assign lane_we[k]   = (st == ST_COPY) && (dst_n < tgt_len);
        assign lane_wa[k]   = dst_n[AW-1:0];

        wgr_lerp #(.DW(DW), .FW(FW)) u_lerp (
            .a    (rd_act[1+2*k]),
            .b    (rd_act[2+2*k]),
            .frac (lane_fr[k]),
            .y    (lane_wd[k])
        );
    end

    // ---------------- banks ----------------
    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic own;
        assign own = (act == 1'(g));

        wgr_bank #(.DW(DW), .DEPTH(MAXLEN), .NRD(NRD)) u_bank (
            .clk  (clk),
            .we_a (own ? smp_tick : lane_we[0]),
            .wa_a (own ? ptr      : lane_wa[0]),
            .wd_a (own ? smp_in   : lane_wd[0]),
            .we_b (!own && lane_we[1]),
            .wa_b (lane_wa[1]),
            .wd_b (lane_wd[1]),
            .ra   (src_ra),
            .rd   (bank_rd[g])
        );
    end
endmodule

// File: rtl/wgr_chk.sv
module wgr_chk #(
    parameter int MAXLEN = 1024,
    parameter int LW     = 11,
    parameter int AW     = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_tick,
    input logic                chg_req,
    input logic [LW-1:0]       chg_len,
    input logic                busy,
    input logic                len_err,
    input wgr_pkg::wgr_state_e st,
    input logic [AW-1:0]       ptr,
    input logic [LW-1:0]       cur_len,
    input logic                act
);
    import wgr_pkg::*;

    logic          bad_req;
    logic          good_req;
    logic [AW-1:0] ptr_next;
    logic [LW:0]   cp_cnt;

    assign bad_req  = chg_req && ((chg_len < LW'(2)) || (chg_len > LW'(MAXLEN)));
    assign good_req = chg_req && !bad_req;
    assign ptr_next = (({1'b0, ptr} + (LW+1)'(1)) == {1'b0, cur_len}) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cp_cnt <= '0;
        else if (st == ST_COPY)  cp_cnt <= cp_cnt + 1'b1;
        else                     cp_cnt <= '0;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        smp_tick |=> (ptr == $past(ptr_next)));                                  // R2
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_len >= LW'(2)) && (cur_len <= LW'(MAXLEN)));                        // R7
    AST_GOOD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        good_req |=> busy);                                                      // R3
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> $past(bad_req));                                             // R7
    AST_BAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_req && !busy) |=> (!busy && $stable(cur_len)));                     // R7
    AST_SWAP_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWAP && !smp_tick) |=> (act != $past(act) && ptr == '0 && st == ST_IDLE)); // R5
    AST_COPY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cp_cnt <= (LW+1)'(MAXLEN / 2));                                          // R3
endmodule

bind wg_resampler wgr_chk #(.MAXLEN(MAXLEN), .LW(LW), .AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_tick (smp_tick),
    .chg_req  (chg_req),
    .chg_len  (chg_len),
    .busy     (busy),
    .len_err  (len_err),
    .st       (st),
    .ptr      (ptr),
    .cur_len  (cur_len),
    .act      (act)
);

// File: tb/wg_resampler_tb_top.sv
module wg_resampler_tb_top;
    localparam int DW     = 16;
    localparam int MAXLEN = 1024;
    localparam int INIT   = 16;
    localparam int LW     = $clog2(MAXLEN + 1);
    localparam int RW     = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_tick = 1'b0;
    logic [DW-1:0] smp_in = '0;
    logic [DW-1:0] smp_out;
    logic          chg_req = 1'b0;
    logic [LW-1:0] chg_len = '0;
    logic [RW-1:0] chg_recip = '0;
    logic          busy;
    logic          len_err;

    int n_vec = 0;
    int n_bad = 0;
    int gen_k = 0;
    int mq [MAXLEN];
    int mlen = INIT;
    int mptr = 0;

    always #4ns clk = ~clk;

    wg_resampler #(.DW(DW), .MAXLEN(MAXLEN), .INIT_LEN(INIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .smp_in(smp_in),
        .smp_out(smp_out), .chg_req(chg_req), .chg_len(chg_len),
        .chg_recip(chg_recip), .busy(busy), .len_err(len_err)
    );

    task automatic check(input string tag, input longint got, input longint exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int next_val();
        gen_k++;
        return ((gen_k * 7919) % 60001) - 30000;
    endfunction

    task automatic do_tick(input string tag, input bit chk);
        int v;
        int exp;
        v = next_val();
        exp = mq[mptr];
        @(negedge clk);
        smp_tick = 1'b1;
        smp_in   = DW'(v);
        @(negedge clk);
        smp_tick = 1'b0;
        if (chk) check(tag, longint'($signed(smp_out)), longint'(exp));
        mq[mptr] = v;
        mptr = (mptr + 1) % mlen;
    endtask

    task automatic do_req(input int n);
        @(negedge clk);
        chg_req   = 1'b1;
        chg_len   = LW'(n);
        chg_recip = (n > 0) ? RW'(65536 / n) : '0;
        @(negedge clk);
        chg_req   = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy && cnt < 5000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    // Model of the rescaling copy, from the requirement formula.
    task automatic model_resample(input int n);
        int tmp [MAXLEN];
        longint rcp, stp, pos, idx, f, d;
        int a, b;
        rcp = 65536 / n;
        stp = longint'(mlen) * rcp;
        for (int j = 0; j < n; j++) begin
            pos = longint'(j) * stp;
            idx = pos >>> 16;
            if (idx > mlen - 1) idx = mlen - 1;
            f   = pos & 65535;
            a   = mq[(mptr + int'(idx)) % mlen];
            b   = mq[(mptr + int'(idx) + 1) % mlen];
            d   = (longint'(b - a) * f) >>> 16;
            tmp[j] = int'(shortint'(a + int'(d)));
        end
        for (int j = 0; j < n; j++) mq[j] = tmp[j];
        mlen = n;
        mptr = 0;
    endtask

    task automatic run_length(input int n);
        int cnt;
        do_req(n);
        check($sformatf("R3 busy after accept len %0d", n), busy, 1);
        wait_idle(cnt);
        check($sformatf("R3 copy cycles len %0d", n), cnt, (n + 1) / 2 + 2);
        model_resample(n);
        for (int j = 0; j < n; j++) do_tick($sformatf("R4 rescaled len %0d j %0d", n, j), 1'b1);
        for (int j = 0; j < n; j++) do_tick($sformatf("R5 delay len %0d", n), 1'b1);
    endtask

    initial begin
        #(8ns * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        int lens [9] = '{8, 40, 2, 3, 1024, 17, 16, 5, 33};
        int bads [3] = '{0, 1, 1025};
        repeat (3) @(negedge clk);
        check("R1 smp_out", smp_out, 0);
        check("R1 busy", busy, 0);
        check("R1 len_err", len_err, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 length: after INIT fills, outputs reproduce the fill
        for (int i = 0; i < INIT; i++) do_tick("R1 fill", 1'b0);
        for (int i = 0; i < 2 * INIT; i++) do_tick("R1 R2 initial delay", 1'b1);

        // R4 R5 R3: sweep of compress and stretch lengths
        foreach (lens[i]) run_length(lens[i]);

        // R7: out-of-range requests ignored
        foreach (bads[i]) begin
            do_req(bads[i]);
            check($sformatf("R7 err pulse len %0d", bads[i]), len_err, 1);
            check("R7 busy stays low", busy, 0);
            @(negedge clk);
            check("R7 err one cycle", len_err, 0);
            for (int j = 0; j < mlen; j++) do_tick("R7 line unchanged", 1'b1);
        end

        // R6: second request during a copy is queued and served after the swap
        do_req(12);
        do_req(20);
        wait_idle(cnt);
        check("R6 busy span for two queued copies", cnt, ((12 + 1) / 2 + 2) + 1 + ((20 + 1) / 2 + 2) - 2);
        model_resample(12);
        model_resample(20);
        for (int j = 0; j < 20; j++) do_tick("R6 queued result", 1'b1);

        // R8: strobes during a long copy keep the old line running
        do_req(1024);
        repeat (3) @(negedge clk);
        for (int j = 0; j < 40; j++) do_tick("R8 playback during copy", 1'b1);
        wait_idle(cnt);
        check("R8 copy finished", busy, 0);
        mlen = 1024;
        mptr = 0;
        for (int j = 0; j < 1024; j++) do_tick("R8 refill", 1'b0);
        for (int j = 0; j < 40; j++) do_tick("R8 R5 delay after swap", 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule